// File: doc/BRIEF.md
# SMBus Host Controller Register Front-End

This block is the byte-wide register window through which software prepares and fires SMBus transactions. Software loads a target address with a direction bit, a command byte and two data bytes. It can also fill a 32-byte block buffer through a single data port whose index advances on every access. A write to the control register then names a protocol and starts the transaction. The block checks the protocol code and takes a snapshot of the request. It then holds a request to a separate bus engine until the engine answers with done. Bytes that the engine returns for a read are placed in the data registers, and the status register reports busy, completion and error.

The block has two states. In ST_IDLE it accepts a launch. A supported code takes the transition GO to ST_WAIT. An unsupported code takes the transition REJECT, which stays in ST_IDLE and raises the error bit. In ST_WAIT the request is held steady. The transition FINISH returns to ST_IDLE when the engine signals done. While in ST_WAIT the engine can also read and write the block buffer through its own index port.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every register reads 0x00 and eng_req is low.
- R2: Only reg_addr[5:0] is decoded. The offsets are status 0x00, control 0x02, command 0x03, target address 0x04, data0 0x05, data1 0x06 and block data 0x07. Any other offset reads 0x00.
- R3: A control write with bit 6 set, made in ST_IDLE with a supported code in bits 4:2, raises eng_req in the next cycle. The engine outputs then carry that code, rw = address register bit 0 (1 = read), the 7-bit target = address register bits 7:1, the command byte, and eng_wdata = {data1, data0}. Status bit 0 (busy) reads 1.
- R4: The supported codes are 0 quick, 1 send/receive byte, 2 byte data, 3 word data and 5 block. A launch with code 4, 6 or 7 raises no request and sets status bit 2 (error).
- R5: One cycle after eng_done is sampled high during ST_WAIT, eng_req is low, busy is 0 and status bit 1 (complete) is 1. If eng_err was high at the same time, bit 2 is also 1.
- R6: A read that completes without error stores eng_rdata[7:0] in data0 for codes 1, 2 and 5 (for code 5 this is the byte count). Code 3 stores eng_rdata[7:0] in data0 and eng_rdata[15:8] in data1. Quick reads, writes and failed reads leave data0 and data1 unchanged.
- R7: Any write to status clears bits 2:1 and resets the block index to 0. Busy is not cleared by it. If a completion falls in the same cycle, the completion wins and its bits stay set.
- R8: Each write or read of block data accesses buffer[index] and then advances the index, which wraps from 31 to 0.
- R9: A control read returns control bits 4:0, with bits 7:5 reading 0, and resets the block index to 0.
- R10: eng_buf_rdata shows buffer[eng_buf_idx]. eng_buf_we writes eng_buf_wdata to that entry, and it takes priority over a software write to the same entry.
- R11: A launch made while busy starts nothing. The held engine outputs stay unchanged, but the control register still takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_rd | input | 1 | Register read strobe; ignored when reg_wr is high |
| reg_addr | input | 8 | Register offset; only bits 5:0 are decoded |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the offset presented this cycle |
| eng_req | output | 1 | Request held high until done |
| eng_prot | output | 3 | Protocol code of the held request |
| eng_rw | output | 1 | 1 = read, 0 = write |
| eng_addr | output | 7 | 7-bit target address |
| eng_cmd | output | 8 | Command byte, or the byte sent for a send-byte |
| eng_wdata | output | 16 | {data1, data0}; the low byte is the length for a block write |
| eng_done | input | 1 | Engine finished the request |
| eng_err | input | 1 | Engine reports a failed transaction, qualified by eng_done |
| eng_rdata | input | 16 | Read result, or the byte count in the low byte for a block read |
| eng_buf_idx | input | 5 | Engine buffer index |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_wdata | input | 8 | Engine buffer write byte |
| eng_buf_rdata | output | 8 | Buffer byte at eng_buf_idx |

## Verification
The status register can see a software clear and an engine completion in the same cycle. Either order of these two would be plausible, so the outcome has to be fixed. The bench provokes it by pulsing a status write on the same clock edge as eng_done, with eng_err both low and high. It then reads status and expects 0x02 or 0x06, which shows that completion won and that busy has dropped. The same collision arises between a software block-data write and an engine buffer write to the same entry. It is judged by reading the entry back through the data port.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam int BYTE_W   = 8;
    localparam int DEC_W    = 6;
    localparam int PROT_W   = 3;
    localparam int TGT_W    = 7;

    localparam logic [DEC_W-1:0] OFS_STAT = 6'h00;
    localparam logic [DEC_W-1:0] OFS_CTRL = 6'h02;
    localparam logic [DEC_W-1:0] OFS_CMD  = 6'h03;
    localparam logic [DEC_W-1:0] OFS_TGT  = 6'h04;
    localparam logic [DEC_W-1:0] OFS_D0   = 6'h05;
    localparam logic [DEC_W-1:0] OFS_D1   = 6'h06;
    localparam logic [DEC_W-1:0] OFS_BLK  = 6'h07;

    localparam int CTRL_GO_BIT = 6;

    localparam logic [PROT_W-1:0] PROT_QUICK = 3'd0;
    localparam logic [PROT_W-1:0] PROT_BYTE  = 3'd1;
    localparam logic [PROT_W-1:0] PROT_BDATA = 3'd2;
    localparam logic [PROT_W-1:0] PROT_WDATA = 3'd3;
    localparam logic [PROT_W-1:0] PROT_BLOCK = 3'd5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [PROT_W-1:0] prot;
        logic              rw;
        logic [TGT_W-1:0]  tgt;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] d0;
        logic [BYTE_W-1:0] d1;
    } xfer_req_t;

    function automatic logic prot_supported(input logic [PROT_W-1:0] p);
        return (p == PROT_QUICK) || (p == PROT_BYTE) || (p == PROT_BDATA) ||
               (p == PROT_WDATA) || (p == PROT_BLOCK);
    endfunction

endpackage

// File: rtl/smbh_ctrl_fsm.sv
module smbh_ctrl_fsm
    import smbh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch,
    input  xfer_req_t launch_req,
    input  logic      stat_clr,
    input  logic      eng_done,
    input  logic      eng_err,
    output logic      eng_req,
    output xfer_req_t req_q,
    output logic      busy,
    output logic      done_flag,
    output logic      err_flag,
    output logic      result_we
);

    seq_state_t state_q, state_d;

    logic code_ok;
    logic in_idle;
    logic go;
    logic reject;
    logic finish;

    assign code_ok = prot_supported(launch_req.prot);
    assign in_idle = (state_q == ST_IDLE);
    assign go      = launch && in_idle && code_ok;
    assign reject  = launch && in_idle && !code_ok;
    assign finish  = (state_q == ST_WAIT) && eng_done;

    // Next-state selection: GO, REJECT (stay), FINISH.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)     state_d = ST_WAIT;
            ST_WAIT: if (finish) state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state.
    always_comb begin
        eng_req   = 1'b0;
        busy      = 1'b0;
        result_we = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                eng_req = 1'b0;
                busy    = 1'b0;
            end
            ST_WAIT: begin
                eng_req   = 1'b1;
                busy      = 1'b1;
                result_we = eng_done && !eng_err && req_q.rw;
            end
            default: ;
        endcase
    end

    // Request snapshot, taken only on GO.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  req_q <= '0;
        else if (go) req_q <= launch_req;
    end

    // Sticky status flags: setting beats a software clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (finish)        done_flag <= 1'b1;
            else if (stat_clr) done_flag <= 1'b0;

            if ((finish && eng_err) || reject) err_flag <= 1'b1;
            else if (stat_clr)                 err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/smbh_data_regs.sv
module smbh_data_regs
    import smbh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_cmd,
    input  logic              we_tgt,
    input  logic              we_d0,
    input  logic              we_d1,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              result_we,
    input  logic [PROT_W-1:0] result_prot,
    input  logic [2*BYTE_W-1:0] result_data,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] tgt_q,
    output logic [BYTE_W-1:0] d0_q,
    output logic [BYTE_W-1:0] d1_q
);

    logic load_lo;
    logic load_hi;

    assign load_lo = result_we && (result_prot != PROT_QUICK);
    assign load_hi = result_we && (result_prot == PROT_WDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            tgt_q <= '0;
        end else begin
            if (we_cmd) cmd_q <= wdata;
            if (we_tgt) tgt_q <= wdata;
        end
    end

    // Engine results take priority over a software write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d0_q <= '0;
            d1_q <= '0;
        end else begin
            if (load_lo)    d0_q <= result_data[BYTE_W-1:0];
            else if (we_d0) d0_q <= wdata;

            if (load_hi)    d1_q <= result_data[2*BYTE_W-1:BYTE_W];
            else if (we_d1) d1_q <= wdata;
        end
    end

endmodule

// File: rtl/smbh_block_buf.sv
module smbh_block_buf
    import smbh_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_rd,
    input  logic              idx_clr,
    input  logic [BYTE_W-1:0] sw_wdata,
    output logic [BYTE_W-1:0] sw_rdata,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic              eng_we,
    input  logic [BYTE_W-1:0] eng_wdata,
    output logic [BYTE_W-1:0] eng_rdata
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [BYTE_W-1:0] cell_q;
        logic eng_hit;
        logic sw_hit;
        assign eng_hit = eng_we && (eng_idx == IDX_W'(g));
        assign sw_hit  = sw_wr && (idx_q == IDX_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cell_q <= '0;
            else if (eng_hit) cell_q <= eng_wdata;
            else if (sw_hit)  cell_q <= sw_wdata;
        end
        assign entry[g] = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               idx_q <= '0;
        else if (idx_clr)         idx_q <= '0;
        else if (sw_wr || sw_rd)  idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end

    assign sw_rdata  = entry[idx_q];
    assign eng_rdata = entry[eng_idx];

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbh_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int IDX_W = $clog2(BUF_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_addr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    output logic                eng_req,
    output logic [PROT_W-1:0]   eng_prot,
    output logic                eng_rw,
    output logic [TGT_W-1:0]    eng_addr,
    output logic [BYTE_W-1:0]   eng_cmd,
    output logic [2*BYTE_W-1:0] eng_wdata,
    input  logic                eng_done,
    input  logic                eng_err,
    input  logic [2*BYTE_W-1:0] eng_rdata,
    input  logic [IDX_W-1:0]    eng_buf_idx,
    input  logic                eng_buf_we,
    input  logic [BYTE_W-1:0]   eng_buf_wdata,
    output logic [BYTE_W-1:0]   eng_buf_rdata
);

    logic [DEC_W-1:0]  ofs;
    logic              rd_only;
    logic [BYTE_W-1:0] ctl_q;
    logic [BYTE_W-1:0] cmd_q, tgt_q, d0_q, d1_q;
    logic [BYTE_W-1:0] blk_rdata;
    logic              busy, done_flag, err_flag, result_we;
    logic              launch, stat_clr, idx_clr;
    xfer_req_t         launch_req;
    xfer_req_t         req_q;

    assign ofs      = reg_addr[DEC_W-1:0];
    assign rd_only  = reg_rd && !reg_wr;
    assign launch   = reg_wr && (ofs == OFS_CTRL) && reg_wdata[CTRL_GO_BIT];
    assign stat_clr = reg_wr && (ofs == OFS_STAT);
    assign idx_clr  = stat_clr || (rd_only && (ofs == OFS_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        ctl_q <= '0;
        else if (reg_wr && ofs == OFS_CTRL) ctl_q <= reg_wdata;
    end

    always_comb begin
        launch_req      = '0;
        launch_req.prot = reg_wdata[4:2];
        launch_req.rw   = tgt_q[0];
        launch_req.tgt  = tgt_q[BYTE_W-1:1];
        launch_req.cmd  = cmd_q;
        launch_req.d0   = d0_q;
        launch_req.d1   = d1_q;
    end

    smbh_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_req (launch_req),
        .stat_clr   (stat_clr),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .eng_req    (eng_req),
        .req_q      (req_q),
        .busy       (busy),
        .done_flag  (done_flag),
        .err_flag   (err_flag),
        .result_we  (result_we)
    );

    smbh_data_regs u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_cmd      (reg_wr && ofs == OFS_CMD),
        .we_tgt      (reg_wr && ofs == OFS_TGT),
        .we_d0       (reg_wr && ofs == OFS_D0),
        .we_d1       (reg_wr && ofs == OFS_D1),
        .wdata       (reg_wdata),
        .result_we   (result_we),
        .result_prot (req_q.prot),
        .result_data (eng_rdata),
        .cmd_q       (cmd_q),
        .tgt_q       (tgt_q),
        .d0_q        (d0_q),
        .d1_q        (d1_q)
    );

    smbh_block_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (reg_wr && ofs == OFS_BLK),
        .sw_rd     (rd_only && ofs == OFS_BLK),
        .idx_clr   (idx_clr),
        .sw_wdata  (reg_wdata),
        .sw_rdata  (blk_rdata),
        .eng_idx   (eng_buf_idx),
        .eng_we    (eng_buf_we),
        .eng_wdata (eng_buf_wdata),
        .eng_rdata (eng_buf_rdata)
    );

    assign eng_prot  = req_q.prot;
    assign eng_rw    = req_q.rw;
    assign eng_addr  = req_q.tgt;
    assign eng_cmd   = req_q.cmd;
    assign eng_wdata = {req_q.d1, req_q.d0};

    always_comb begin
        unique case (ofs)
            OFS_STAT: reg_rdata = {5'b0, err_flag, done_flag, busy};
            OFS_CTRL: reg_rdata = {3'b0, ctl_q[4:0]};
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_TGT:  reg_rdata = tgt_q;
            OFS_D0:   reg_rdata = d0_q;
            OFS_D1:   reg_rdata = d1_q;
            OFS_BLK:  reg_rdata = blk_rdata;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/smbh_checker.sv
module smbh_checker
    import smbh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [7:0]        reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              eng_req,
    input logic [PROT_W-1:0] eng_prot,
    input logic [TGT_W-1:0]  eng_addr,
    input logic              eng_done
);

    logic ctl_wr_go;
    assign ctl_wr_go = reg_wr && (reg_addr[5:0] == OFS_CTRL) && reg_wdata[CTRL_GO_BIT];

    assert_launch_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> $past(ctl_wr_go));

    assert_bad_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_req && ctl_wr_go && !prot_supported(reg_wdata[4:2])) |=> !eng_req);

    assert_req_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> prot_supported(eng_prot));

    assert_done_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done) |=> !eng_req);

    assert_busy_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr[5:0] == OFS_STAT) |-> (reg_rdata[0] == eng_req));

    assert_ctl_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr[5:0] == OFS_CTRL) |-> (reg_rdata[7:5] == 3'b0));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_prot) && $stable(eng_addr)));

endmodule

bind smbus_host_regs smbh_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_req   (eng_req),
    .eng_prot  (eng_prot),
    .eng_addr  (eng_addr),
    .eng_done  (eng_done)
);

// File: tb/smbus_host_regs_tb_top.sv
module smbus_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic        eng_req, eng_rw;
    logic [2:0]  eng_prot;
    logic [6:0]  eng_addr;
    logic [7:0]  eng_cmd;
    logic [15:0] eng_wdata;
    logic        eng_done = 1'b0, eng_err = 1'b0;
    logic [15:0] eng_rdata = '0;
    logic [4:0]  eng_buf_idx = '0;
    logic        eng_buf_we = 1'b0;
    logic [7:0]  eng_buf_wdata = '0, eng_buf_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] sh_d0, sh_d1, sh_cmd, sh_tgt;
    logic [7:0] blk_exp [32];

    always #2 clk = ~clk;

    smbus_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_req(eng_req), .eng_prot(eng_prot), .eng_rw(eng_rw),
        .eng_addr(eng_addr), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
        .eng_done(eng_done), .eng_err(eng_err), .eng_rdata(eng_rdata),
        .eng_buf_idx(eng_buf_idx), .eng_buf_we(eng_buf_we),
        .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic complete(input logic err, input logic [15:0] rdat);
        @(negedge clk);
        eng_done = 1'b1; eng_err = err; eng_rdata = rdat;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    function automatic bit code_ok(input logic [2:0] p);
        return p == 0 || p == 1 || p == 2 || p == 3 || p == 5;
    endfunction

    // Expected data0/data1 after a completed transaction.
    function automatic logic [15:0] exp_data(input logic [2:0] p, input logic rw,
        input logic err, input logic [15:0] r, input logic [7:0] d0, input logic [7:0] d1);
        logic [7:0] n0 = d0, n1 = d1;
        if (rw && !err) begin
            if (p == 1 || p == 2 || p == 5) n0 = r[7:0];
            if (p == 3) begin n0 = r[7:0]; n1 = r[15:8]; end
        end
        return {n1, n0};
    endfunction

    task automatic load_regs(input logic [7:0] t, input logic [7:0] c,
                             input logic [7:0] a, input logic [7:0] b);
        wr(8'h04, t); wr(8'h03, c); wr(8'h05, a); wr(8'h06, b);
        sh_tgt = t; sh_cmd = c; sh_d0 = a; sh_d1 = b;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [15:0] ed;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(8'(a), v);
            check("R1 reset reg", {24'b0, v}, 32'h0);
        end
        check("R1 reset req", {31'b0, eng_req}, 32'h0);

        // R2 aliasing and unmapped offsets
        wr(8'h43, 8'h5A);
        rd(8'h03, v); check("R2 alias write 0x43->cmd", {24'b0, v}, 32'h5A);
        rd(8'hC3, v); check("R2 alias read 0xC3", {24'b0, v}, 32'h5A);
        rd(8'h01, v); check("R2 unmapped 0x01", {24'b0, v}, 32'h0);
        rd(8'h3F, v); check("R2 unmapped 0x3F", {24'b0, v}, 32'h0);

        // Random transactions: R3 R4 R5 R6
        for (int n = 0; n < 48; n++) begin
            logic [2:0]  p;
            logic        e;
            logic [15:0] r;
            logic [7:0]  ctl;
            p = (n < 8) ? 3'(n) : 3'($urandom_range(0, 7));
            load_regs(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            wr(8'h00, 8'hFF);
            ctl = {1'($urandom), 1'b1, 1'($urandom), p, 2'($urandom)};
            wr(8'h02, ctl);
            if (code_ok(p)) begin
                check("R3 req raised", {31'b0, eng_req}, 32'h1);
                check("R3 prot", {29'b0, eng_prot}, {29'b0, p});
                check("R3 rw", {31'b0, eng_rw}, {31'b0, sh_tgt[0]});
                check("R3 target", {25'b0, eng_addr}, {25'b0, sh_tgt[7:1]});
                check("R3 cmd", {24'b0, eng_cmd}, {24'b0, sh_cmd});
                check("R3 wdata", {16'b0, eng_wdata}, {16'b0, sh_d1, sh_d0});
                rd(8'h00, v); check("R3 busy status", {24'b0, v}, 32'h01);
                repeat ($urandom_range(0, 3)) @(negedge clk);
                e = ($urandom_range(0, 3) == 0);
                r = 16'($urandom);
                complete(e, r);
                check("R5 req dropped", {31'b0, eng_req}, 32'h0);
                rd(8'h00, v); check("R5 status", {24'b0, v}, e ? 32'h06 : 32'h02);
                ed = exp_data(p, sh_tgt[0], e, r, sh_d0, sh_d1);
                rd(8'h05, v); check("R6 data0", {24'b0, v}, {24'b0, ed[7:0]});
                rd(8'h06, v); check("R6 data1", {24'b0, v}, {24'b0, ed[15:8]});
            end else begin
                check("R4 no req", {31'b0, eng_req}, 32'h0);
                rd(8'h00, v); check("R4 error status", {24'b0, v}, 32'h04);
            end
            rd(8'h02, v); check("R9 ctl readback", {24'b0, v}, {27'b0, ctl[4:0]});
        end

        // R7 collision: status clear with completion in the same cycle
        for (int k = 0; k < 2; k++) begin
            load_regs(8'h21, 8'h10, 8'h00, 8'h00);
            wr(8'h02, 8'h48);
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 8'h00;
            eng_done = 1'b1; eng_err = 1'(k); eng_rdata = 16'hBEEF;
            @(negedge clk);
            reg_wr = 1'b0; eng_done = 1'b0; eng_err = 1'b0;
            rd(8'h00, v); check("R7 completion wins clear", {24'b0, v}, k ? 32'h06 : 32'h02);
            wr(8'h00, 8'h00);
            rd(8'h00, v); check("R7 clear", {24'b0, v}, 32'h0);
        end

        // R7 busy survives a status write
        load_regs(8'h20, 8'h11, 8'h00, 8'h00);
        wr(8'h02, 8'h44);
        wr(8'h00, 8'h00);
        rd(8'h00, v); check("R7 busy kept", {24'b0, v}, 32'h01);

        // R11 launch while busy ignored
        wr(8'h02, 8'h54);
        check("R11 prot held", {29'b0, eng_prot}, 32'h1);
        check("R11 cmd held", {24'b0, eng_cmd}, 32'h11);
        rd(8'h02, v); check("R11 ctl updated", {24'b0, v}, 32'h14);
        complete(1'b0, 16'h0);
        rd(8'h00, v); check("R11 single completion", {24'b0, v}, 32'h02);

        // R8 index wrap
        wr(8'h00, 8'h00);
        for (int i = 0; i < 34; i++) begin
            v = 8'($urandom);
            wr(8'h07, v);
            blk_exp[i % 32] = v;
        end
        rd(8'h02, v);
        for (int i = 0; i < 32; i++) begin
            rd(8'h07, v); check("R8 block entry", {24'b0, v}, {24'b0, blk_exp[i]});
        end
        rd(8'h07, v); check("R8 wrap to entry0", {24'b0, v}, {24'b0, blk_exp[0]});

        // R7 status write resets index; R9 control read resets index
        rd(8'h07, v); rd(8'h07, v);
        wr(8'h00, 8'h00);
        rd(8'h07, v); check("R7 index reset", {24'b0, v}, {24'b0, blk_exp[0]});
        rd(8'h07, v);
        rd(8'h02, v);
        rd(8'h07, v); check("R9 index reset", {24'b0, v}, {24'b0, blk_exp[0]});

        // R10 engine port
        eng_buf_idx = 5'd5; #1;
        check("R10 engine read", {24'b0, eng_buf_rdata}, {24'b0, blk_exp[5]});
        @(negedge clk);
        eng_buf_we = 1'b1; eng_buf_idx = 5'd7; eng_buf_wdata = 8'hA5;
        @(negedge clk);
        eng_buf_we = 1'b0;
        blk_exp[7] = 8'hA5;
        // collision on entry 0: software and engine write same cycle
        wr(8'h00, 8'h00);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h07; reg_wdata = 8'h11;
        eng_buf_we = 1'b1; eng_buf_idx = 5'd0; eng_buf_wdata = 8'h3C;
        @(negedge clk);
        reg_wr = 1'b0; eng_buf_we = 1'b0;
        blk_exp[0] = 8'h3C;
        rd(8'h02, v);
        for (int i = 0; i < 8; i++) begin
            rd(8'h07, v); check("R10 buffer after engine writes", {24'b0, v}, {24'b0, blk_exp[i]});
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule